// File: doc/BRIEF.md
# Mixed-Sign Single-Cycle Integer Multiplier

This block is the integer multiply datapath of a 16-bit processor. Two operands arrive together with a flag for each one that says whether it is two's-complement or unsigned, and a size select that chooses between full 16-bit operands and byte operands. The block widens each operand to 17 bits. The extra top bit is a copy of the operand's sign bit when that operand is signed, and zero when it is unsigned. A single signed 17x17 core then gives the right answer for the signed, unsigned and mixed cases.

Mixed mode means operand A is signed and operand B is unsigned. Because each operand has its own flag, the opposite pairing also works. In byte mode only the low byte of each operand is used, and it is widened according to its own flag. The result is the low 32 bits of the exact product. It is captured in a register on the clock edge where the valid strobe is high, so it appears one clock later together with a result-valid flag. The result then holds until the next strobe.

Top module: `mixmul_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next output state is `out_valid` = 0 and `product` = 0, even if `in_valid` is high in that cycle.
- R2: `out_valid` is high in exactly those cycles that follow a rising edge at which `in_valid` was high.
- R3: With `a_signed` = 0, `b_signed` = 0 and `byte_mode` = 0, `product` is the unsigned product of the two 16-bit operands (for example, 0xFFFF by 0xFFFF gives 0xFFFE0001).
- R4: With both sign flags = 1 and `byte_mode` = 0, `product` is the two's-complement product of the two 16-bit operands, written as 32 bits (for example, 0x8000 by 0x7FFF gives 0xC0008000).
- R5: With `a_signed` = 1 and `b_signed` = 0, operand A is taken as signed and operand B as unsigned (for example, 0xFFFF by 0xFFFF gives 0xFFFF0001). The flags act on each operand separately, so `a_signed` = 0 with `b_signed` = 1 gives the mirror case.
- R6: With `byte_mode` = 1, only bits 7:0 of each operand are used and bits 15:8 have no effect. Each byte is sign-extended when its flag is 1 and zero-extended when its flag is 0. The 32-bit result is the product of the two extended bytes.
- R7: In a cycle where `in_valid` is low, `product` keeps its previous value, whatever happens on the operand inputs.
- R8: Strobes in consecutive cycles each produce their own result, one cycle after the strobe, with no bubble between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid; start a multiply |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| a_signed | input | 1 | 1: operand A is two's-complement; 0: operand A is unsigned |
| b_signed | input | 1 | 1: operand B is two's-complement; 0: operand B is unsigned |
| byte_mode | input | 1 | 1: multiply the low bytes only; 0: multiply the full 16-bit operands |
| out_valid | output | 1 | Result register was loaded on the last edge |
| product | output | 32 | Registered low 32 bits of the product |

## Verification
Two functions can land in the same cycle. The first is the result of one strobe becoming visible. The second is the capture of the next strobe's operands, or a reset arriving alongside a strobe. The bench provokes the first case by driving three back-to-back strobes that use different sign and size settings. It checks each result one cycle after its own strobe, which confirms that no stale or mixed value appears. It provokes the second case by raising `in_valid` together with `rst`. A cleared result and a low valid flag are the only correct outcome.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;

  typedef enum logic {
    OPND_A = 1'b0,
    OPND_B = 1'b1
  } opnd_e;

  localparam int NUM_OPNDS = 2;

  function automatic logic fill_bit(input logic msb, input logic is_signed);
    return msb & is_signed;
  endfunction

endpackage

// File: rtl/mixmul_extend.sv
module mixmul_extend #(
  parameter int OP_W   = 16,
  parameter int BYTE_W = 8,
  parameter int EXT_W  = OP_W + 1
) (
  input  logic [OP_W-1:0]  op,
  input  logic             is_signed,
  input  logic             byte_mode,
  output logic [EXT_W-1:0] ext
);
  import mixmul_pkg::*;

  localparam int BYTE_PAD = EXT_W - BYTE_W;
  localparam int WORD_PAD = EXT_W - OP_W;

  logic [BYTE_W-1:0] low_byte;
  logic              byte_fill;
  logic              word_fill;

  assign low_byte  = op[BYTE_W-1:0];
  assign byte_fill = fill_bit(low_byte[BYTE_W-1], is_signed);
  assign word_fill = fill_bit(op[OP_W-1], is_signed);

  always_comb begin
    if (byte_mode) begin
      ext = {{BYTE_PAD{byte_fill}}, low_byte};
    end else begin
      ext = {{WORD_PAD{word_fill}}, op};
    end
  end

endmodule

// File: rtl/mixmul_core.sv
module mixmul_core #(
  parameter int EXT_W     = 17,
  parameter int OUT_W     = 32,
  parameter bit USE_ARRAY = 1'b1
) (
  input  logic [EXT_W-1:0] a_ext,
  input  logic [EXT_W-1:0] b_ext,
  output logic [OUT_W-1:0] prod
);

  generate
    if (USE_ARRAY) begin : g_array
      logic [OUT_W-1:0] a_wide;
      logic [OUT_W-1:0] rows [EXT_W];

      assign a_wide = {{(OUT_W-EXT_W){a_ext[EXT_W-1]}}, a_ext};

      for (genvar i = 0; i < EXT_W; i++) begin : g_row
        logic [OUT_W-1:0] shifted;
        assign shifted = a_wide << i;
        if (i == EXT_W - 1) begin : g_neg
          assign rows[i] = b_ext[i] ? (~shifted + OUT_W'(1)) : '0;
        end else begin : g_pos
          assign rows[i] = b_ext[i] ? shifted : '0;
        end
      end

      always_comb begin
        prod = '0;
        for (int k = 0; k < EXT_W; k++) begin
          prod = prod + rows[k];
        end
      end
    end else begin : g_behav
      logic signed [OUT_W-1:0] sprod;
      assign sprod = $signed(a_ext) * $signed(b_ext);
      assign prod  = sprod;
    end
  endgenerate

endmodule

// File: rtl/mixmul_outreg.sv
module mixmul_outreg #(
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OUT_W-1:0] d,
  output logic             q_valid,
  output logic [OUT_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) begin
        q <= d;
      end
    end
  end

endmodule

// File: rtl/mixmul_top.sv
module mixmul_top #(
  parameter int OP_W      = 16,
  parameter int BYTE_W    = 8,
  parameter bit USE_ARRAY = 1'b1,
  parameter int EXT_W     = OP_W + 1,
  parameter int RES_W     = 2 * OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             a_signed,
  input  logic             b_signed,
  input  logic             byte_mode,
  output logic             out_valid,
  output logic [RES_W-1:0] product
);
  import mixmul_pkg::*;

  logic [OP_W-1:0]  opnd   [NUM_OPNDS];
  logic             sgn    [NUM_OPNDS];
  logic [EXT_W-1:0] ext    [NUM_OPNDS];
  logic [RES_W-1:0] prod_d;

  assign opnd[OPND_A] = op_a;
  assign opnd[OPND_B] = op_b;
  assign sgn[OPND_A]  = a_signed;
  assign sgn[OPND_B]  = b_signed;

  generate
    for (genvar k = 0; k < NUM_OPNDS; k++) begin : g_ext
      mixmul_extend #(
        .OP_W  (OP_W),
        .BYTE_W(BYTE_W),
        .EXT_W (EXT_W)
      ) u_ext (
        .op       (opnd[k]),
        .is_signed(sgn[k]),
        .byte_mode(byte_mode),
        .ext      (ext[k])
      );
    end
  endgenerate

  mixmul_core #(
    .EXT_W    (EXT_W),
    .OUT_W    (RES_W),
    .USE_ARRAY(USE_ARRAY)
  ) u_core (
    .a_ext(ext[OPND_A]),
    .b_ext(ext[OPND_B]),
    .prod (prod_d)
  );

  mixmul_outreg #(
    .OUT_W(RES_W)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (in_valid),
    .d      (prod_d),
    .q_valid(out_valid),
    .q      (product)
  );

endmodule

// File: rtl/mixmul_chk.sv
module mixmul_chk #(
  parameter int OP_W  = 16,
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [OP_W-1:0]  op_a,
  input logic [OP_W-1:0]  op_b,
  input logic             a_signed,
  input logic             b_signed,
  input logic             byte_mode,
  input logic             out_valid,
  input logic [RES_W-1:0] product
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: after a reset edge the outputs are cleared
  always @(negedge clk) begin
    if (rst_q) begin
      a_r1_reset_clears: assert (!out_valid && product == '0)
        else $error("a_r1_reset_clears");
    end
  end

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(product));

  // R6: unsigned byte by unsigned byte fits in 16 bits
  a_r6_ubyte_range: assert property (@(posedge clk) disable iff (rst)
    (in_valid && byte_mode && !a_signed && !b_signed) |=> (product[RES_W-1:16] == '0));

  // R4: a zero word operand gives zero regardless of signs
  a_r4_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !byte_mode && (op_a == '0 || op_b == '0)) |=> (product == '0));

endmodule

bind mixmul_top mixmul_chk #(
  .OP_W (OP_W),
  .RES_W(RES_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_a     (op_a),
  .op_b     (op_b),
  .a_signed (a_signed),
  .b_signed (b_signed),
  .byte_mode(byte_mode),
  .out_valid(out_valid),
  .product  (product)
);

// File: tb/tb_mixmul_top.sv
module tb_mixmul_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] op_a, op_b;
  logic        a_signed, b_signed, byte_mode;
  logic        out_valid;
  logic [31:0] product;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mixmul_top dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .a_signed (a_signed),
    .b_signed (b_signed),
    .byte_mode(byte_mode),
    .out_valid(out_valid),
    .product  (product)
  );

  // {op_a, op_b, a_signed, b_signed, byte_mode, expected}
  localparam int NV = 14;
  localparam logic [66:0] VEC [NV] = '{
    {16'h0003, 16'h0005, 3'b000, 32'h0000000F},  // R3
    {16'hFFFF, 16'hFFFF, 3'b000, 32'hFFFE0001},  // R3
    {16'h1234, 16'h5678, 3'b000, 32'h06260060},  // R3
    {16'hFFFF, 16'hFFFF, 3'b110, 32'h00000001},  // R4
    {16'h8000, 16'h8000, 3'b110, 32'h40000000},  // R4
    {16'h8000, 16'h7FFF, 3'b110, 32'hC0008000},  // R4
    {16'h1234, 16'h0000, 3'b110, 32'h00000000},  // R4
    {16'hFFFF, 16'hFFFF, 3'b100, 32'hFFFF0001},  // R5
    {16'h8000, 16'hFFFF, 3'b100, 32'h80008000},  // R5
    {16'hFFFF, 16'hFFFE, 3'b010, 32'hFFFE0002},  // R5 mirror
    {16'h12FF, 16'h34FF, 3'b001, 32'h0000FE01},  // R6 unsigned bytes
    {16'hAB80, 16'hCD80, 3'b111, 32'h00004000},  // R6 signed bytes
    {16'h00FF, 16'h0002, 3'b111, 32'hFFFFFFFE},  // R6
    {16'h7F80, 16'hA5FF, 3'b101, 32'hFFFF8080}   // R6 mixed bytes
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [2:0] m,
                       input logic v);
    op_a      = a;
    op_b      = b;
    a_signed  = m[2];
    b_signed  = m[1];
    byte_mode = m[0];
    in_valid  = v;
  endtask

  initial begin
    rst = 1'b1;
    drive(16'h0, 16'h0, 3'b000, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", {31'b0, out_valid}, 32'h0);
    check("R1 reset product", product, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][66:51], VEC[i][50:35], VEC[i][34:32], 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R2 valid vec%0d", i), {31'b0, out_valid}, 32'h1);
      check($sformatf("R3-6 product vec%0d", i), product, VEC[i][31:0]);
    end

    // R7: hold while operands change with no strobe
    @(negedge clk);
    drive(16'h5555, 16'hAAAA, 3'b110, 1'b0);
    repeat (3) @(negedge clk);
    check("R7 hold product", product, VEC[NV-1][31:0]);
    check("R2 no valid without strobe", {31'b0, out_valid}, 32'h0);

    // R8: back-to-back strobes with different modes
    drive(16'h0007, 16'h0009, 3'b000, 1'b1);
    @(negedge clk);
    check("R8 b2b first", product, 32'h0000003F);
    drive(16'hFFFE, 16'h0003, 3'b110, 1'b1);
    @(negedge clk);
    check("R8 b2b second", product, 32'hFFFFFFFA);
    check("R8 b2b valid", {31'b0, out_valid}, 32'h1);
    drive(16'hEE10, 16'h9910, 3'b001, 1'b1);
    @(negedge clk);
    check("R8 b2b third R6", product, 32'h00000100);
    in_valid = 1'b0;

    // R1: reset together with a strobe
    @(negedge clk);
    rst = 1'b1;
    drive(16'h0002, 16'h0002, 3'b000, 1'b1);
    @(negedge clk);
    check("R1 reset beats strobe valid", {31'b0, out_valid}, 32'h0);
    check("R1 reset beats strobe product", product, 32'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule